// File: doc/BRIEF.md
# Dual-Port RAM with Selectable Write Behaviour

This block is a synchronous dual-port RAM with two independent access ports, A and B. Both ports run on one shared clock. Each port has its own clock enable, write enable, address, write data, read-data register and local reset. On every enabled edge a port either reads the addressed word into its output register or writes its data into the array. A per-port parameter sets what that port's output register shows on a write: it can keep its previous value, echo the incoming data, or present the word that is being overwritten.

Each output register can be cleared asynchronously in two ways: by the port's own active-high local reset, or by an active-low global reset that clears both ports at once. The storage array is never cleared. The parameters are checked at elaboration, and a port may select the overwritten-word behaviour only at a data width of 9, 18 or 36 bits.

Top module: `dpram_wmode`

## Requirements
- R1: With a port in NORMAL mode (mode code 0), an edge with clock enable high and write enable low loads that port's output with the addressed word, and an edge with both high leaves the output unchanged.
- R2: With a port in ECHO mode (mode code 1), an edge with clock enable and write enable high loads that port's output with that port's write data.
- R3: With a port in OLD-FIRST mode (mode code 2), an enabled edge loads the output with the word the address held before the edge, and a write on that edge still stores the new data.
- R4: A word is written only when clock enable and write enable are both high at the clock edge. With clock enable low, the port's output holds and the array is not changed, even if write enable is high.
- R5: When both ports write the same address on one edge, the array keeps port A's data.
- R6: A read on one port of an address that the other port writes on the same edge returns the data from before the edge.
- R7: The read data appears on the output one clock edge after the address is presented.
- R8: A port's local reset clears that port's output to zero at once, without waiting for a clock edge, and leaves the other port's output and the array untouched.
- R9: Driving the global reset low clears both outputs to zero at once, and the array contents survive it.
- R10: A port set to OLD-FIRST mode with a data width other than 9, 18 or 36 is rejected at elaboration. The legality test is a package function that returns 1 only for those three widths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| grst_n | input | 1 | Global asynchronous clear of both output registers, active low |
| a_ce | input | 1 | Port A clock enable |
| a_we | input | 1 | Port A write enable |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rst | input | 1 | Port A local asynchronous output clear, active high |
| a_rdata | output | DATA_W | Port A registered read data |
| b_ce | input | 1 | Port B clock enable |
| b_we | input | 1 | Port B write enable |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rst | input | 1 | Port B local asynchronous output clear, active high |
| b_rdata | output | DATA_W | Port B registered read data |

## Verification
Every clocked result is due exactly one rising edge after its inputs are applied: a read word, an echoed write, an overwritten word, and a stored word as seen by a later read. The bench changes inputs just after a falling edge. A behavioural model computes the expected outputs at each rising edge, and the outputs are compared at the next falling edge, half a period after they settle. The two resets act without a clock, so the bench also samples the outputs one nanosecond after a reset is asserted, before any further edge arrives. Two instances cover all three modes with the same stimulus.

// File: rtl/dpram_pkg.sv
`timescale 1ns/1ps
package dpram_pkg;

    typedef enum logic [1:0] {
        WM_NORMAL    = 2'd0,
        WM_ECHO      = 2'd1,
        WM_OLD_FIRST = 2'd2
    } wmode_e;

    // R10: widths at which the overwritten-word mode is legal
    function automatic bit old_first_width_ok(input int w);
        return (w == 9) || (w == 18) || (w == 36);
    endfunction

endpackage

// File: rtl/dpram_store.sv
`timescale 1ns/1ps
module dpram_store #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 6,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              a_wr,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_old,
    input  logic              b_wr,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_old
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Pre-edge contents; a read on either port sees these (R6)
    assign a_old = mem[a_addr];
    assign b_old = mem[b_addr];

    // Port A is applied last, so it wins a same-address collision (R5)
    always_ff @(posedge clk) begin
        if (b_wr) mem[b_addr] <= b_wdata;
        if (a_wr) mem[a_addr] <= a_wdata;
    end

endmodule

// File: rtl/dpram_rdport.sv
`timescale 1ns/1ps
module dpram_rdport
    import dpram_pkg::*;
#(
    parameter int     DATA_W = 18,
    parameter wmode_e MODE   = WM_NORMAL
) (
    input  logic              clk,
    input  logic              grst_n,
    input  logic              lrst,
    input  logic              ce,
    input  logic              we,
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);

    logic [DATA_W-1:0] q_next;

    always_comb begin
        q_next = q;
        if (ce) begin
            unique case (MODE)
                WM_NORMAL:    q_next = we ? q : old_word;
                WM_ECHO:      q_next = we ? wdata : old_word;
                WM_OLD_FIRST: q_next = old_word;
                default:      q_next = old_word;
            endcase
        end
    end

    always_ff @(posedge clk or posedge lrst or negedge grst_n) begin
        if (lrst || !grst_n) q <= '0;
        else                 q <= q_next;
    end

endmodule

// File: rtl/dpram_wmode.sv
`timescale 1ns/1ps
module dpram_wmode
    import dpram_pkg::*;
#(
    parameter int     DATA_W = 18,
    parameter int     ADDR_W = 6,
    parameter wmode_e MODE_A = WM_NORMAL,
    parameter wmode_e MODE_B = WM_NORMAL
) (
    input  logic              clk,
    input  logic              grst_n,
    input  logic              a_ce,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              a_rst,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_ce,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic              b_rst,
    output logic [DATA_W-1:0] b_rdata
);

    // R10: reject OLD-FIRST at unsupported widths
    if (MODE_A == WM_OLD_FIRST && !old_first_width_ok(DATA_W)) begin : g_bad_mode_a
        $error("port A: OLD-FIRST mode needs DATA_W of 9, 18 or 36");
    end
    if (MODE_B == WM_OLD_FIRST && !old_first_width_ok(DATA_W)) begin : g_bad_mode_b
        $error("port B: OLD-FIRST mode needs DATA_W of 9, 18 or 36");
    end

    logic              a_wr, b_wr;
    logic [DATA_W-1:0] a_old, b_old;

    assign a_wr = a_ce & a_we;
    assign b_wr = b_ce & b_we;

    dpram_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .a_wr    (a_wr),
        .a_addr  (a_addr),
        .a_wdata (a_wdata),
        .a_old   (a_old),
        .b_wr    (b_wr),
        .b_addr  (b_addr),
        .b_wdata (b_wdata),
        .b_old   (b_old)
    );

    dpram_rdport #(.DATA_W(DATA_W), .MODE(MODE_A)) u_port_a (
        .clk      (clk),
        .grst_n   (grst_n),
        .lrst     (a_rst),
        .ce       (a_ce),
        .we       (a_we),
        .old_word (a_old),
        .wdata    (a_wdata),
        .q        (a_rdata)
    );

    dpram_rdport #(.DATA_W(DATA_W), .MODE(MODE_B)) u_port_b (
        .clk      (clk),
        .grst_n   (grst_n),
        .lrst     (b_rst),
        .ce       (b_ce),
        .we       (b_we),
        .old_word (b_old),
        .wdata    (b_wdata),
        .q        (b_rdata)
    );

endmodule

// File: rtl/dpram_wmode_chk.sv
`timescale 1ns/1ps
module dpram_wmode_chk
    import dpram_pkg::*;
#(
    parameter int     DATA_W = 18,
    parameter wmode_e MODE_A = WM_NORMAL,
    parameter wmode_e MODE_B = WM_NORMAL
) (
    input logic              clk,
    input logic              grst_n,
    input logic              a_ce,
    input logic              a_we,
    input logic [DATA_W-1:0] a_wdata,
    input logic              a_rst,
    input logic [DATA_W-1:0] a_rdata,
    input logic              b_ce,
    input logic              b_we,
    input logic [DATA_W-1:0] b_wdata,
    input logic              b_rst,
    input logic [DATA_W-1:0] b_rdata
);

    a_r4_a_idle_holds: assert property (@(posedge clk) disable iff (!grst_n || a_rst)
        !a_ce |=> $stable(a_rdata));
    a_r4_b_idle_holds: assert property (@(posedge clk) disable iff (!grst_n || b_rst)
        !b_ce |=> $stable(b_rdata));

    a_r8_a_local_clear: assert property (@(posedge clk) disable iff (!grst_n)
        a_rst |-> a_rdata == '0);
    a_r8_b_local_clear: assert property (@(posedge clk) disable iff (!grst_n)
        b_rst |-> b_rdata == '0);

    a_r9_global_clear: assert property (@(posedge clk) disable iff (a_rst || b_rst)
        !grst_n |-> (a_rdata == '0) && (b_rdata == '0));

    if (MODE_A == WM_NORMAL) begin : g_a_normal
        a_r1_a_write_holds: assert property (@(posedge clk) disable iff (!grst_n || a_rst)
            a_ce && a_we |=> $stable(a_rdata));
    end
    if (MODE_A == WM_ECHO) begin : g_a_echo
        a_r2_a_echo: assert property (@(posedge clk) disable iff (!grst_n || a_rst)
            a_ce && a_we |=> a_rdata == $past(a_wdata));
    end
    if (MODE_B == WM_NORMAL) begin : g_b_normal
        a_r1_b_write_holds: assert property (@(posedge clk) disable iff (!grst_n || b_rst)
            b_ce && b_we |=> $stable(b_rdata));
    end
    if (MODE_B == WM_ECHO) begin : g_b_echo
        a_r2_b_echo: assert property (@(posedge clk) disable iff (!grst_n || b_rst)
            b_ce && b_we |=> b_rdata == $past(b_wdata));
    end

endmodule

bind dpram_wmode dpram_wmode_chk #(
    .DATA_W (DATA_W),
    .MODE_A (MODE_A),
    .MODE_B (MODE_B)
) u_chk (
    .clk     (clk),
    .grst_n  (grst_n),
    .a_ce    (a_ce),
    .a_we    (a_we),
    .a_wdata (a_wdata),
    .a_rst   (a_rst),
    .a_rdata (a_rdata),
    .b_ce    (b_ce),
    .b_we    (b_we),
    .b_wdata (b_wdata),
    .b_rst   (b_rst),
    .b_rdata (b_rdata)
);

// File: tb/dpram_wmode_tb.sv
`timescale 1ns/1ps
module dpram_wmode_tb;
    import dpram_pkg::*;

    localparam int DW = 18;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          grst_n = 1'b0;
    logic          a_ce = 0, a_we = 0, a_rst = 0;
    logic          b_ce = 0, b_we = 0, b_rst = 0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;
    logic [DW-1:0] a_q1, b_q1, a_q2, b_q2;

    int    checks = 0;
    int    failures = 0;
    string tag = "R9";

    // Instance 1: A NORMAL, B ECHO.  Instance 2: both OLD-FIRST.
    dpram_wmode #(.DATA_W(DW), .ADDR_W(AW), .MODE_A(WM_NORMAL), .MODE_B(WM_ECHO)) u_dut (
        .clk(clk), .grst_n(grst_n),
        .a_ce(a_ce), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rst(a_rst), .a_rdata(a_q1),
        .b_ce(b_ce), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rst(b_rst), .b_rdata(b_q1));

    dpram_wmode #(.DATA_W(DW), .ADDR_W(AW), .MODE_A(WM_OLD_FIRST), .MODE_B(WM_OLD_FIRST)) u_dut2 (
        .clk(clk), .grst_n(grst_n),
        .a_ce(a_ce), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rst(a_rst), .a_rdata(a_q2),
        .b_ce(b_ce), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rst(b_rst), .b_rdata(b_q2));

    // Behavioural reference
    logic [DW-1:0] ref_mem [DEPTH];
    logic [DW-1:0] ea1 = '0, eb1 = '0, ea2 = '0, eb2 = '0;

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 'x;
    end

    function automatic logic [DW-1:0] step(input int mode, input logic ce, input logic we,
                                           input logic [DW-1:0] old, input logic [DW-1:0] wd,
                                           input logic [DW-1:0] cur);
        if (!ce) return cur;
        case (mode)
            0:       return we ? cur : old;
            1:       return we ? wd : old;
            default: return old;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [DW-1:0] oa, ob;
        oa = ref_mem[a_addr];
        ob = ref_mem[b_addr];
        if (b_ce && b_we) ref_mem[b_addr] = b_wdata;
        if (a_ce && a_we) ref_mem[a_addr] = a_wdata;
        if (a_rst || !grst_n) begin ea1 = '0; ea2 = '0; end
        else begin
            ea1 = step(0, a_ce, a_we, oa, a_wdata, ea1);
            ea2 = step(2, a_ce, a_we, oa, a_wdata, ea2);
        end
        if (b_rst || !grst_n) begin eb1 = '0; eb2 = '0; end
        else begin
            eb1 = step(1, b_ce, b_we, ob, b_wdata, eb1);
            eb2 = step(2, b_ce, b_we, ob, b_wdata, eb2);
        end
    end

    task automatic cmp(input string req, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        if ($isunknown(exp)) return;
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare on every falling edge, half a cycle after the outputs settle
    always @(negedge clk) begin
        cmp(tag, "u_dut.a", a_q1, ea1);
        cmp(tag, "u_dut.b", b_q1, eb1);
        cmp(tag, "u_dut2.a", a_q2, ea2);
        cmp(tag, "u_dut2.b", b_q2, eb2);
    end

    task automatic cyc(input string t,
                       input logic ace, input logic awe, input int aad, input logic [DW-1:0] awd,
                       input logic bce, input logic bwe, input int bad, input logic [DW-1:0] bwd);
        @(negedge clk); #1;
        tag = t;
        a_ce = ace; a_we = awe; a_addr = AW'(aad); a_wdata = awd;
        b_ce = bce; b_we = bwe; b_addr = AW'(bad); b_wdata = bwd;
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        return DW'((i * 32'h1357) ^ 32'h2A5);
    endfunction

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R10: legality function
        checks += 6;
        if (old_first_width_ok(9)  !== 1'b1) begin failures++; $display("FAIL R10 w9 actual=0 expected=1");  end
        if (old_first_width_ok(18) !== 1'b1) begin failures++; $display("FAIL R10 w18 actual=0 expected=1"); end
        if (old_first_width_ok(36) !== 1'b1) begin failures++; $display("FAIL R10 w36 actual=0 expected=1"); end
        if (old_first_width_ok(8)  !== 1'b0) begin failures++; $display("FAIL R10 w8 actual=1 expected=0");  end
        if (old_first_width_ok(16) !== 1'b0) begin failures++; $display("FAIL R10 w16 actual=1 expected=0"); end
        if (old_first_width_ok(32) !== 1'b0) begin failures++; $display("FAIL R10 w32 actual=1 expected=0"); end

        // R9: reset state
        repeat (3) cyc("R9", 0, 0, 0, '0, 0, 0, 0, '0);
        @(negedge clk); #1; grst_n = 1'b1;

        // Fill through A (R1 hold on write, R3 old word) and B echo (R2)
        for (int i = 0; i < DEPTH; i += 2) begin
            cyc("R2", 1, 1, i, pat(i), 1, 1, i + 1, pat(i + 1));
        end
        // R3: overwrite while OLD-FIRST shows the previous word
        cyc("R3", 1, 1, 2, pat(100), 1, 1, 3, pat(101));
        // R1/R7: reads on both ports with varied addresses
        for (int i = 0; i < DEPTH; i++) begin
            cyc("R7", 1, 0, i, '0, 1, 0, DEPTH - 1 - i, '0);
        end
        // R4: clock enable low with write enable high: nothing stored, outputs hold
        cyc("R4", 0, 1, 4, pat(200), 0, 1, 5, pat(201));
        cyc("R4", 0, 1, 6, pat(202), 0, 0, 7, '0);
        cyc("R4", 1, 0, 4, '0, 1, 0, 5, '0);
        // R5: same-address collision, A wins
        cyc("R5", 1, 1, 9, 18'h11111, 1, 1, 9, 18'h22222);
        cyc("R5", 1, 0, 9, '0, 1, 0, 9, '0);
        // R6: cross-port read of a word being written
        cyc("R6", 1, 1, 10, 18'h0ABCD, 1, 0, 10, '0);
        cyc("R6", 1, 0, 11, '0, 1, 1, 11, 18'h3C3C3);
        cyc("R6", 1, 0, 11, '0, 1, 0, 10, '0);
        // R8: local reset of A is immediate and leaves B alone
        cyc("R8", 0, 0, 0, '0, 0, 0, 0, '0);
        @(negedge clk); #1;
        tag = "R8"; a_rst = 1'b1; ea1 = '0; ea2 = '0;
        #1;
        cmp("R8", "async u_dut.a", a_q1, '0);
        cmp("R8", "async u_dut2.a", a_q2, '0);
        cmp("R8", "async u_dut.b kept", b_q1, eb1);
        cmp("R8", "async u_dut2.b kept", b_q2, eb2);
        cyc("R8", 1, 0, 3, '0, 1, 0, 2, '0);
        @(negedge clk); #1; a_rst = 1'b0;
        cyc("R8", 1, 0, 3, '0, 0, 0, 0, '0);
        // R8: local reset of B
        @(negedge clk); #1;
        b_rst = 1'b1; eb1 = '0; eb2 = '0;
        #1;
        cmp("R8", "async u_dut.b", b_q1, '0);
        cmp("R8", "async u_dut2.b", b_q2, '0);
        cmp("R8", "async u_dut.a kept", a_q1, ea1);
        @(negedge clk); #1; b_rst = 1'b0;
        // R9: global reset clears both at once, array kept
        cyc("R9", 1, 0, 8, '0, 1, 0, 12, '0);
        @(negedge clk); #1;
        tag = "R9"; grst_n = 1'b0; ea1 = '0; ea2 = '0; eb1 = '0; eb2 = '0;
        #1;
        cmp("R9", "async u_dut.a", a_q1, '0);
        cmp("R9", "async u_dut.b", b_q1, '0);
        cmp("R9", "async u_dut2.a", a_q2, '0);
        cmp("R9", "async u_dut2.b", b_q2, '0);
        @(negedge clk); #1; grst_n = 1'b1;
        cyc("R9", 1, 0, 8, '0, 1, 0, 12, '0);
        cyc("R1", 1, 0, 0, '0, 1, 0, 15, '0);
        cyc("R1", 0, 0, 0, '0, 0, 0, 0, '0);
        @(negedge clk); #1;

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule